// File: doc/BRIEF.md
# Retired Memory Access Trace Recorder

This block watches the memory accesses that a core retires and builds one trace record per instruction for a formal-verification style retirement port. For each access it receives the physical address, the access size in bytes, the read and/or write data, and a flag that says whether the access ended in an exception. It then presents a registered record. The record holds the address, a present flag, 256-bit read and write data fields, and a 32-bit byte mask for each direction.

The record is written when the retire strobe is high. It is wiped when the instruction-start strobe is high. Data is kept only for the bytes the access covers, and it is zero-extended into the wide fields. A faulting access still logs its address, but it leaves the data and mask fields as they were. An access wider than 16 bytes cannot be represented in the record, so it raises a sticky error flag instead.

Top module: `trc_recorder`

## Requirements
- R1: During and right after reset, every record output is zero: present flag, address, both data fields, both masks and the error flag.
- R2: A retire strobe sets the present flag and loads the zero-extended access address into the record address on the following clock edge. This happens whether or not the access faulted.
- R3: A retire of a non-faulting read of width w (w no more than 16) does two things. It sets read-mask bit i for every i below w and clears all other bits, so width 4 gives 0x0000000F. It loads the low w bytes of the read data into the read-data field and zeroes every byte above them.
- R4: A retire of a non-faulting write of width w (w no more than 16) fills the write-data field and the write mask in the same way as R3, using the write data.
- R5: An access flagged as both read and write fills the read and write fields of the same record in one retire.
- R6: A retire with the fault flag set leaves both data fields and both masks unchanged. Only the address and the present flag update.
- R7: A retire whose width exceeds 16 sets the error flag and leaves the data fields and masks unchanged. The error flag then stays set until an instruction start or a reset.
- R8: An instruction-start strobe with no retire in the same cycle clears the present flag, the address, both data fields, both masks and the error flag on the next edge.
- R9: When instruction start and retire are high in the same cycle, the result is as if the record were cleared first and the access recorded afterwards. Fields the access does not write read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_start | input | 1 | New instruction begins; clear the record |
| retire | input | 1 | An access completes this cycle; record it |
| acc_addr | input | ADDR_W (32) | Physical address of the access |
| acc_width | input | WID_W (6) | Access size in bytes |
| acc_read | input | 1 | Access returned read data |
| acc_write | input | 1 | Access stored write data |
| acc_fault | input | 1 | Access ended in an exception |
| rd_data | input | 128 | Read data, byte 0 in bits 7:0 |
| wr_data | input | 128 | Write data, byte 0 in bits 7:0 |
| rec_valid | output | 1 | Record holds at least one access |
| rec_addr | output | REC_ADDR_W (64) | Zero-extended address of the last recorded access |
| rec_rdata | output | 256 | Recorded read data |
| rec_rmask | output | 32 | Byte mask of recorded read data |
| rec_wdata | output | 256 | Recorded write data |
| rec_wmask | output | 32 | Byte mask of recorded write data |
| rec_err | output | 1 | An access wider than 16 bytes was seen in this instruction |

## Verification
Every record output is one register stage away from its strobes. An access presented before a rising edge therefore shows in the record after that edge, with no further delay, for the address, the present flag, the data, the masks and the error flag alike. The bench drives each access on a falling edge and compares the whole record on the next falling edge, before it drives the next access. It keeps its own expected record, built from the requirements, and carries that record across accesses. As a result, fields that a fault, an oversize width or the other direction must leave unchanged are still compared after each access. The vector with start and retire together checks the clear-then-record ordering in that same single cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int MAX_ACC_BYTES = 16;
    localparam int MAX_ACC_BITS  = MAX_ACC_BYTES * 8;
    localparam int REC_BYTES     = 32;
    localparam int REC_BITS      = REC_BYTES * 8;

    typedef struct packed {
        logic [REC_BITS-1:0]  data;
        logic [REC_BYTES-1:0] mask;
    } lane_t;

    // Low w bits set, capped at the record width.
    function automatic logic [REC_BYTES-1:0] byte_mask(input int unsigned w);
        logic [REC_BYTES-1:0] m;
        for (int i = 0; i < REC_BYTES; i++) begin
            m[i] = (i < w);
        end
        return m;
    endfunction

    // Turn a byte mask into a bit mask.
    function automatic logic [REC_BITS-1:0] expand_mask(input logic [REC_BYTES-1:0] m);
        logic [REC_BITS-1:0] e;
        for (int i = 0; i < REC_BYTES; i++) begin
            e[i*8 +: 8] = {8{m[i]}};
        end
        return e;
    endfunction
endpackage

// File: rtl/trc_acc_decode.sv
module trc_acc_decode
    import trc_pkg::*;
#(
    parameter int WID_W = 6
) (
    input  logic                 retire,
    input  logic [WID_W-1:0]     acc_width,
    input  logic                 acc_read,
    input  logic                 acc_write,
    input  logic                 acc_fault,
    output logic                 width_bad,
    output logic                 cap_rd,
    output logic                 cap_wr,
    output logic [REC_BYTES-1:0] bmask
);
    logic data_ok;

    always_comb begin
        width_bad = retire && (32'(acc_width) > MAX_ACC_BYTES);
        data_ok   = retire && !acc_fault && !width_bad;
        cap_rd    = data_ok && acc_read;
        cap_wr    = data_ok && acc_write;
        bmask     = byte_mask(32'(acc_width));
    end
endmodule

// File: rtl/trc_lane.sv
module trc_lane
    import trc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    cap,
    input  logic [REC_BYTES-1:0]    bmask,
    input  logic [MAX_ACC_BITS-1:0] din,
    output lane_t                   q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap) begin
            q.data <= REC_BITS'(din) & expand_mask(bmask);
            q.mask <= bmask;
        end else if (clr) begin
            q <= '0;
        end
    end
endmodule

// File: rtl/trc_recorder.sv
module trc_recorder
    import trc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int REC_ADDR_W = 64,
    parameter int WID_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    insn_start,
    input  logic                    retire,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [WID_W-1:0]        acc_width,
    input  logic                    acc_read,
    input  logic                    acc_write,
    input  logic                    acc_fault,
    input  logic [MAX_ACC_BITS-1:0] rd_data,
    input  logic [MAX_ACC_BITS-1:0] wr_data,
    output logic                    rec_valid,
    output logic [REC_ADDR_W-1:0]   rec_addr,
    output logic [REC_BITS-1:0]     rec_rdata,
    output logic [REC_BYTES-1:0]    rec_rmask,
    output logic [REC_BITS-1:0]     rec_wdata,
    output logic [REC_BYTES-1:0]    rec_wmask,
    output logic                    rec_err
);
    localparam int NLANES = 2;  // 0: read, 1: write

    logic                    width_bad;
    logic                    cap_rd, cap_wr;
    logic [REC_BYTES-1:0]    bmask;
    logic                    cap_v [NLANES];
    logic [MAX_ACC_BITS-1:0] din_v [NLANES];
    lane_t                   lane_q [NLANES];

    trc_acc_decode #(.WID_W(WID_W)) u_dec (
        .retire   (retire),
        .acc_width(acc_width),
        .acc_read (acc_read),
        .acc_write(acc_write),
        .acc_fault(acc_fault),
        .width_bad(width_bad),
        .cap_rd   (cap_rd),
        .cap_wr   (cap_wr),
        .bmask    (bmask)
    );

    always_comb begin
        cap_v[0] = cap_rd;
        cap_v[1] = cap_wr;
        din_v[0] = rd_data;
        din_v[1] = wr_data;
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        trc_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .clr  (insn_start),
            .cap  (cap_v[g]),
            .bmask(bmask),
            .din  (din_v[g]),
            .q    (lane_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_addr  <= '0;
            rec_err   <= 1'b0;
        end else begin
            if (retire) begin
                rec_valid <= 1'b1;
                rec_addr  <= REC_ADDR_W'(acc_addr);
            end else if (insn_start) begin
                rec_valid <= 1'b0;
                rec_addr  <= '0;
            end
            if (width_bad) begin
                rec_err <= 1'b1;
            end else if (insn_start) begin
                rec_err <= 1'b0;
            end
        end
    end

    always_comb begin
        rec_rdata = lane_q[0].data;
        rec_rmask = lane_q[0].mask;
        rec_wdata = lane_q[1].data;
        rec_wmask = lane_q[1].mask;
    end
endmodule

// File: rtl/trc_recorder_chk.sv
module trc_recorder_chk
    import trc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int REC_ADDR_W = 64,
    parameter int WID_W      = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  insn_start,
    input logic                  retire,
    input logic [ADDR_W-1:0]     acc_addr,
    input logic [WID_W-1:0]      acc_width,
    input logic                  acc_read,
    input logic                  acc_fault,
    input logic                  rec_valid,
    input logic [REC_ADDR_W-1:0] rec_addr,
    input logic [REC_BITS-1:0]   rec_rdata,
    input logic [REC_BYTES-1:0]  rec_rmask,
    input logic [REC_BITS-1:0]   rec_wdata,
    input logic [REC_BYTES-1:0]  rec_wmask,
    input logic                  rec_err
);
    // R2
    addr_logged_chk: assert property (@(posedge clk) disable iff (rst)
        retire |=> rec_valid && (rec_addr == REC_ADDR_W'($past(acc_addr))));

    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_start && !retire) |=> !rec_valid && rec_rmask == '0 && rec_wmask == '0 && !rec_err);

    // R6
    fault_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && acc_fault && !insn_start) |=>
            $stable(rec_rdata) && $stable(rec_rmask) && $stable(rec_wdata) && $stable(rec_wmask));

    // R7
    oversize_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && 32'(acc_width) > MAX_ACC_BYTES) |=> rec_err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_err && !insn_start) |=> rec_err);

    // R3
    rmask_count_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && acc_read && !acc_fault && 32'(acc_width) <= MAX_ACC_BYTES) |=>
            $countones(rec_rmask) == 32'($past(acc_width)));
endmodule

bind trc_recorder trc_recorder_chk #(
    .ADDR_W(ADDR_W), .REC_ADDR_W(REC_ADDR_W), .WID_W(WID_W)
) u_chk (
    .clk(clk), .rst(rst), .insn_start(insn_start), .retire(retire),
    .acc_addr(acc_addr), .acc_width(acc_width), .acc_read(acc_read),
    .acc_fault(acc_fault), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_rdata(rec_rdata), .rec_rmask(rec_rmask), .rec_wdata(rec_wdata),
    .rec_wmask(rec_wmask), .rec_err(rec_err)
);

// File: tb/sim_trc_recorder.sv
module sim_trc_recorder;
    logic         clk = 1'b0;
    logic         rst;
    logic         insn_start, retire, acc_read, acc_write, acc_fault;
    logic [31:0]  acc_addr;
    logic [5:0]   acc_width;
    logic [127:0] rd_data, wr_data;
    logic         rec_valid, rec_err;
    logic [63:0]  rec_addr;
    logic [255:0] rec_rdata, rec_wdata;
    logic [31:0]  rec_rmask, rec_wmask;

    always #10 clk = ~clk;  // 50 MHz

    trc_recorder u0 (
        .clk(clk), .rst(rst), .insn_start(insn_start), .retire(retire),
        .acc_addr(acc_addr), .acc_width(acc_width), .acc_read(acc_read),
        .acc_write(acc_write), .acc_fault(acc_fault), .rd_data(rd_data),
        .wr_data(wr_data), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_rdata(rec_rdata), .rec_rmask(rec_rmask), .rec_wdata(rec_wdata),
        .rec_wmask(rec_wmask), .rec_err(rec_err)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // expected record
    logic         e_valid, e_err;
    logic [63:0]  e_addr;
    logic [255:0] e_rdata, e_wdata;
    logic [31:0]  e_rmask, e_wmask;

    typedef struct packed {
        logic         start, ret, rd, wr, flt;
        logic [5:0]   w;
        logic [31:0]  addr;
        logic [127:0] rdat, wdat;
        logic [3:0]   req;
    } vec_t;

    localparam logic [127:0] PAT_A = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
    localparam logic [127:0] PAT_B = 128'h11223344_55667788_99AABBCC_DDEEFF00;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 6'd4,  32'h0000_1000, PAT_A, PAT_B, 4'd3}, // R3 R2
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 6'd8,  32'h8000_2008, PAT_A, PAT_B, 4'd4}, // R4
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 6'd16, 32'hFFFF_FFF0, PAT_B, PAT_A, 4'd5}, // R5
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 6'd2,  32'h0000_3000, PAT_A, PAT_A, 4'd6}, // R6
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 6'd17, 32'h0000_4000, PAT_A, PAT_B, 4'd7}, // R7
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 6'd1,  32'h0000_4004, PAT_B, PAT_B, 4'd7}, // R7 sticky
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 6'd0,  32'h0,         PAT_A, PAT_A, 4'd8}, // R8
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 6'd3,  32'h0000_5001, PAT_A, PAT_B, 4'd3}, // R3
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 6'd2,  32'h0000_6002, PAT_A, PAT_B, 4'd9}, // R9
        '{1'b0,1'b1,1'b0,1'b1,1'b1, 6'd4,  32'h0000_7000, PAT_A, PAT_A, 4'd2}  // R2 fault
    };

    function automatic logic [255:0] keep_bytes(input logic [127:0] d, input int w);
        logic [255:0] r = '0;
        for (int i = 0; i < 16; i++) if (i < w) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] low_ones(input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) if (i < w) r[i] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "valid", 256'(rec_valid), 256'(e_valid));
        chk(req, "addr",  256'(rec_addr),  256'(e_addr));
        chk(req, "err",   256'(rec_err),   256'(e_err));
        chk(req, "rdata", rec_rdata,       e_rdata);
        chk(req, "rmask", 256'(rec_rmask), 256'(e_rmask));
        chk(req, "wdata", rec_wdata,       e_wdata);
        chk(req, "wmask", 256'(rec_wmask), 256'(e_wmask));
    endtask

    task automatic clear_model();
        e_valid = 0; e_err = 0; e_addr = '0;
        e_rdata = '0; e_wdata = '0; e_rmask = '0; e_wmask = '0;
    endtask

    // Drive on a falling edge, check on the next falling edge.
    task automatic apply(input vec_t v);
        insn_start = v.start; retire = v.ret; acc_read = v.rd; acc_write = v.wr;
        acc_fault = v.flt; acc_width = v.w; acc_addr = v.addr;
        rd_data = v.rdat; wr_data = v.wdat;
        if (v.start) clear_model();
        if (v.ret) begin
            e_valid = 1; e_addr = 64'(v.addr);
            if (int'(v.w) > 16) e_err = 1;
            else if (!v.flt) begin
                if (v.rd) begin e_rdata = keep_bytes(v.rdat, int'(v.w)); e_rmask = low_ones(int'(v.w)); end
                if (v.wr) begin e_wdata = keep_bytes(v.wdat, int'(v.w)); e_wmask = low_ones(int'(v.w)); end
            end
        end
        @(negedge clk);
        insn_start = 0; retire = 0;
        chk_all($sformatf("R%0d", v.req));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; insn_start = 0; retire = 0; acc_read = 0; acc_write = 0;
        acc_fault = 0; acc_width = '0; acc_addr = '0; rd_data = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        clear_model();
        chk_all("R1");  // reset state
        rst = 0;
        @(negedge clk);
        chk_all("R1");  // still zero with no strobes

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R1: reset in the middle of a filled record
        apply('{1'b0,1'b1,1'b1,1'b1,1'b0, 6'd16, 32'hABCD_0000, PAT_A, PAT_B, 4'd5});
        rst = 1;
        @(negedge clk);
        rst = 0;
        clear_model();
        chk_all("R1");

        // R3: zero-width read gives empty mask and zero data
        apply('{1'b0,1'b1,1'b1,1'b0,1'b0, 6'd0, 32'h0000_0010, PAT_A, PAT_B, 4'd3});
        // R7: oversize write leaves earlier write fields alone
        apply('{1'b0,1'b1,1'b0,1'b1,1'b0, 6'd8,  32'h0000_0020, PAT_A, PAT_B, 4'd4});
        apply('{1'b0,1'b1,1'b0,1'b1,1'b0, 6'd63, 32'h0000_0030, PAT_A, PAT_A, 4'd7});
        // R8: start clears the error flag
        apply('{1'b1,1'b0,1'b0,1'b0,1'b0, 6'd0, 32'h0, PAT_A, PAT_A, 4'd8});

        finish_run();
    end
endmodule